// File: doc/BRIEF.md
# Serial Bit Clock Generator for an SPI Master

This block derives the serial bit clock of an SPI-style master from the faster module clock. A 16-bit divisor sets the ratio. The bit clock toggles only while a transfer is marked active. At all other times it rests at the level chosen by a polarity input. Alongside the clock it emits two one-cycle strobes, a drive strobe and a capture strobe, on alternate bit-clock edges. A neighbouring shift register uses them to launch and sample data without looking at the clock itself.

Only even divisors are meaningful. The lowest divisor bit is ignored, and a divisor that rounds to zero switches the clock off. The divisor and the phase selection are taken only between transfers, so a transfer always runs at one fixed rate. Dropping the active flag stops the clock within one module-clock cycle and restarts the count for the next transfer.

Top module: `sclk_gen`

## Requirements
- R1: While `rstN` is low, `sclk`, `driveStb` and `captureStb` are all 0.
- R2: With an effective divisor D = `divisor` with bit 0 cleared and D >= 2, number the rising module-clock edges that sample `xferActive` high as 1, 2, 3, and so on. `sclk` toggles at edges D/2, D, 3D/2, and so on. Each level therefore lasts exactly D/2 module-clock cycles, which gives a bit clock of the module clock divided by D.
- R3: Bit 0 of `divisor` is ignored. An odd value behaves exactly like the even value one below it, so a value of 1 behaves like 0.
- R4: An effective divisor of 0 keeps `sclk` at its idle level for the whole transfer, and neither strobe is raised.
- R5: While `xferActive` is low, `sclk` takes the value of `idlePol` at each rising edge. A change to `idlePol` during a transfer has no effect on `sclk`.
- R6: Each `sclk` toggle during a transfer coincides with exactly one strobe, high for one cycle in the same cycle as the new `sclk` level. The kinds alternate. The first toggle carries `driveStb` when `drvFirst` is 1 and `captureStb` when `drvFirst` is 0. The two strobes are never high together.
- R7: At the first rising edge that samples `xferActive` low, `sclk` returns to `idlePol` and both strobes go low. No partial pulse follows. The next transfer counts again from edge 1.
- R8: `divisor` and `drvFirst` are sampled only while `xferActive` is low. Changes made during a transfer take effect from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Clock divisor; bit 0 ignored, 0 turns the clock off |
| xferActive | input | 1 | High while a transfer is in progress |
| idlePol | input | 1 | Level of `sclk` between transfers |
| drvFirst | input | 1 | 1: first edge of a transfer is a drive edge; 0: a capture edge |
| sclk | output | 1 | Serial bit clock |
| driveStb | output | 1 | One-cycle strobe on drive edges |
| captureStb | output | 1 | One-cycle strobe on capture edges |

## Verification
The assertions assume that `xferActive`, `divisor`, `drvFirst` and `idlePol` are synchronous to `clk`. They also assume that a transfer begins only after the divisor and phase it should use have been presented for at least one idle edge. The stimulus changes inputs only on falling clock edges. It settles each transfer's settings two idle cycles before raising `xferActive`. It then changes the divisor, phase or polarity in the middle of some transfers only to confirm that those changes are ignored.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  // Command from the control half to the datapath half, valid per module-clock cycle.
  typedef struct packed {
    logic edgeEv;   // bit clock toggles at the coming edge
    logic isDrive;  // that toggle is a drive edge (else capture)
  } edgeCmd_t;
endpackage

// File: rtl/sclk_gen_ctrl.sv
module sclk_gen_ctrl
  import sclk_gen_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             xferActive,
  input  logic             drvFirst,
  output edgeCmd_t         cmd
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] halfLat;
  logic [HALF_W-1:0] cnt;
  logic              phaseLat;
  logic              edgeOdd;
  logic              tick;

  // A toggle is due when the half-period counter reaches its last count.
  assign tick = xferActive && (halfLat != '0) && (cnt == halfLat - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfLat  <= '0;
      phaseLat <= 1'b0;
      cnt      <= '0;
      edgeOdd  <= 1'b0;
    end else if (!xferActive) begin
      halfLat  <= HALF_W'(divisor >> 1);
      phaseLat <= drvFirst;
      cnt      <= '0;
      edgeOdd  <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      edgeOdd  <= ~edgeOdd;
    end else if (halfLat != '0) begin
      cnt      <= cnt + HALF_W'(1);
    end
  end

  assign cmd.edgeEv  = tick;
  assign cmd.isDrive = phaseLat ^ edgeOdd;

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && $past(xferActive)) |-> ($stable(halfLat) && $stable(phaseLat))); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (halfLat != '0) |-> (cnt < halfLat)); // R2
  AST_OFF_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (halfLat == '0) |-> (cnt == '0 && !tick)); // R4
endmodule

// File: rtl/sclk_gen_dp.sv
module sclk_gen_dp
  import sclk_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     xferActive,
  input  logic     idlePol,
  input  edgeCmd_t cmd,
  output logic     sclk,
  output logic     driveStb,
  output logic     captureStb
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclk       <= 1'b0;
      driveStb   <= 1'b0;
      captureStb <= 1'b0;
    end else if (!xferActive) begin
      sclk       <= idlePol;
      driveStb   <= 1'b0;
      captureStb <= 1'b0;
    end else begin
      driveStb   <= cmd.edgeEv &&  cmd.isDrive;
      captureStb <= cmd.edgeEv && !cmd.isDrive;
      if (cmd.edgeEv) sclk <= ~sclk;
    end
  end

  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |=> (sclk == $past(idlePol))); // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({driveStb, captureStb})); // R6
  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (driveStb || captureStb) |-> (sclk != $past(sclk))); // R6
  AST_EDGE_HAS_STB: assert property (@(posedge clk) disable iff (!rstN)
    ($past(xferActive) && (sclk != $past(sclk))) |-> (driveStb || captureStb)); // R6
  AST_DRV_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    driveStb |=> !driveStb); // R6
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |=> (!driveStb && !captureStb)); // R7
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             xferActive,
  input  logic             idlePol,
  input  logic             drvFirst,
  output logic             sclk,
  output logic             driveStb,
  output logic             captureStb
);
  edgeCmd_t cmd;

  sclk_gen_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .divisor    (divisor),
    .xferActive (xferActive),
    .drvFirst   (drvFirst),
    .cmd        (cmd)
  );

  sclk_gen_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .idlePol    (idlePol),
    .cmd        (cmd),
    .sclk       (sclk),
    .driveStb   (driveStb),
    .captureStb (captureStb)
  );
endmodule

// File: tb/sim_sclk_gen.sv
`timescale 1ns/1ps
module sim_sclk_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = '0;
  logic        xferActive = 1'b0;
  logic        idlePol = 1'b0;
  logic        drvFirst = 1'b0;
  logic        sclk, driveStb, captureStb;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sclk_gen u0 (
    .clk(clk), .rstN(rstN), .divisor(divisor), .xferActive(xferActive),
    .idlePol(idlePol), .drvFirst(drvFirst),
    .sclk(sclk), .driveStb(driveStb), .captureStb(captureStb)
  );

  function automatic int halfOf(logic [15:0] d);
    return int'(d >> 1);
  endfunction

  function automatic logic expSclk(int n, int h, logic pol);
    if (h == 0) return pol;
    return pol ^ (((n / h) % 2) != 0);
  endfunction

  // kind: 1 = drive strobe, 0 = capture strobe
  function automatic logic expStb(int n, int h, logic ph, logic kind);
    int k;
    if (h == 0 || (n % h) != 0) return 1'b0;
    k = n / h;
    return (((k % 2) == 1) == ph) == kind;
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic runXfer(logic [15:0] div, logic pol, logic ph, int len,
                         int mid, logic [15:0] newDiv, logic newPol, logic newPh);
    int h;
    string tagClk;
    h = halfOf(div);
    @(negedge clk);
    divisor = div; idlePol = pol; drvFirst = ph; xferActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sclk, pol, "R5 idle level before transfer");
    xferActive = 1'b1;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (mid > 0 && n > mid) tagClk = "R8 sclk after mid-transfer change";
      else if (h == 0) tagClk = "R4 sclk with clock off";
      else if (div[0]) tagClk = "R3 sclk with odd divisor";
      else tagClk = "R2 sclk level";
      chk(sclk, expSclk(n, h, pol), tagClk);
      chk(driveStb, expStb(n, h, ph, 1'b1), "R6 drive strobe");
      chk(captureStb, expStb(n, h, ph, 1'b0), "R6 capture strobe");
      if (n == mid) begin
        divisor = newDiv; idlePol = newPol; drvFirst = newPh;
      end
    end
    xferActive = 1'b0;
    @(negedge clk);
    chk(sclk, idlePol, "R7 return to idle");
    chk(driveStb | captureStb, 1'b0, "R7 strobes low after stop");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sclk, 1'b0, "R1 sclk in reset");
    chk(driveStb, 1'b0, "R1 driveStb in reset");
    chk(captureStb, 1'b0, "R1 captureStb in reset");
    rstN = 1'b1;

    // R5: idle level follows polarity input
    @(negedge clk); idlePol = 1'b1;
    @(negedge clk); chk(sclk, 1'b1, "R5 idle follows pol high");
    idlePol = 1'b0;
    @(negedge clk); chk(sclk, 1'b0, "R5 idle follows pol low");

    // Directed corners
    runXfer(16'd2, 1'b0, 1'b1, 12, 0, 16'd0, 1'b0, 1'b0);     // R2 fastest rate, R6 drive first
    runXfer(16'd2, 1'b1, 1'b0, 12, 0, 16'd0, 1'b1, 1'b0);     // R6 capture first, pol high
    runXfer(16'd6, 1'b0, 1'b0, 25, 0, 16'd0, 1'b0, 1'b0);     // R2
    runXfer(16'd7, 1'b1, 1'b1, 25, 0, 16'd0, 1'b1, 1'b1);     // R3 odd rounds down
    runXfer(16'd1, 1'b0, 1'b1, 10, 0, 16'd0, 1'b0, 1'b1);     // R3, R4 one acts as off
    runXfer(16'd0, 1'b1, 1'b1, 10, 0, 16'd0, 1'b1, 1'b1);     // R4 off
    runXfer(16'd65534, 1'b0, 1'b1, 40, 0, 16'd0, 1'b0, 1'b1); // R2 largest divisor
    runXfer(16'd4, 1'b0, 1'b1, 30, 5, 16'd10, 1'b1, 1'b0);    // R8 and R5 mid-transfer changes
    runXfer(16'd10, 1'b1, 1'b0, 7, 0, 16'd0, 1'b1, 1'b0);     // R7 stop mid-level, no runt
    runXfer(16'd10, 1'b1, 1'b0, 12, 0, 16'd0, 1'b1, 1'b0);    // R7 restart counts from 1

    // Constrained random transfers
    for (int i = 0; i < 40; i++) begin
      logic [15:0] d, nd;
      int len, mid;
      d   = 16'($urandom % 40);
      nd  = 16'($urandom % 40);
      len = 1 + int'($urandom % 80);
      mid = (($urandom % 3) == 0) ? int'($urandom % len) : 0;
      runXfer(d, 1'($urandom), 1'($urandom), len, mid, nd, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule